// File: doc/BRIEF.md
# DC-Offset External Fault Detector

This block watches the local line currents of a differential protection zone for a large DC offset. Such an offset can later saturate a current transformer and produce false differential current. When the offset is high and the differential current is still small compared with the restraint current, the block treats the event as a fault outside the zone and raises a detect flag. Other protection logic uses the flag to make its tripping more secure.

Each of the two terminal inputs supplies a precomputed fixed-point DC magnitude and a fundamental AC magnitude, together with a zone-membership enable. A terminal's offset counts only if it is large against a per-unit floor and also large against that terminal's own AC level. The qualifying condition must last three power cycles, counted in sample strobes, before the flag sets. Once set, the flag is sealed in. Any later growth of the differential current is then ignored, and the flag drops only when no terminal still shows a high offset.

Top module: `dc_offset_efd`

## Requirements
- R1: A synchronous active-high reset clears the detect flag and the qualification count, so that after reset a full three-cycle qualification is needed again.
- R2: A terminal's DC level is high only when DC × 5 is strictly greater than the nominal count `NOM_PU`, which means strictly more than 0.2 pu. A value exactly at 0.2 pu does not count.
- R3: A terminal's DC level is high only when DC × 10 is strictly greater than AC × 3 for that same terminal. Equality does not count.
- R4: A terminal's high-DC result is ignored while that terminal's zone enable is low.
- R5: The two terminals are checked independently, and either qualified terminal alone is enough.
- R6: The differential check passes only when DIF × 2 is strictly less than RST.
- R7: The detect flag rises in the cycle after the `3 × SPC`-th consecutive strobe on which the combined condition holds. It does not rise after one strobe fewer.
- R8: Before the flag is set, any cycle in which the combined condition is false clears the count, so a full `3 × SPC` strobes are needed afterwards.
- R9: Once the flag is set, it stays set while any qualified terminal has high DC, whatever the differential and restraint values are.
- R10: While the flag is set, a cycle with no qualified high-DC terminal clears it in the next cycle. Setting it again takes a full new qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe, `SPC` per power cycle |
| dc_mag_w | input | MAG_W | DC magnitude, first terminal |
| ac_mag_w | input | MAG_W | Fundamental AC magnitude, first terminal |
| zone_en_w | input | 1 | First terminal belongs to the zone |
| dc_mag_x | input | MAG_W | DC magnitude, second terminal |
| ac_mag_x | input | MAG_W | Fundamental AC magnitude, second terminal |
| zone_en_x | input | 1 | Second terminal belongs to the zone |
| dif_mag | input | MAG_W | Differential current magnitude |
| rst_mag | input | MAG_W | Restraint current magnitude |
| efd_out | output | 1 | Latched external-fault detect flag |

## Verification
Two functions can act in the same cycle: the final qualifying strobe that would complete the three-cycle count, and the low-differential check dropping out. The bench counts up to one strobe short of the limit. It then raises the differential current in exactly the cycle of the final strobe and expects the flag to stay low, because the count clears instead of completing. It then checks that a fresh full-length qualification is needed. A second pairing is also checked. Once sealed in, a high differential current must not clear the flag, but the DC decay that follows must clear it exactly one cycle later.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;
    // Fixed-point ratio constants, applied by cross-multiplication
    localparam int FLOOR_MUL = 5;   // DC*5 > NOM  <=> DC > 0.2 pu
    localparam int KDC_DC    = 10;  // DC*10 > AC*3 <=> DC > 0.3*AC
    localparam int KDC_AC    = 3;
    localparam int KRD_DIF   = 2;   // DIF*2 < RST <=> DIF < 0.5*RST
    localparam int NTERM     = 2;
    localparam int GUARD_W   = 4;   // headroom bits for multipliers up to 15
endpackage

// File: rtl/dcfd_term_chk.sv
module dcfd_term_chk
    import dcfd_pkg::*;
#(
    parameter int MAG_W  = 16,
    parameter int NOM_PU = 1000
) (
    input  logic [MAG_W-1:0] dc_mag,
    input  logic [MAG_W-1:0] ac_mag,
    input  logic             zone_en,
    output logic             dc_hi_q
);
    localparam int PW = MAG_W + GUARD_W;

    logic [PW-1:0] dc_floor_d;
    logic [PW-1:0] dc_ratio_d;
    logic [PW-1:0] ac_ratio_d;
    logic          above_floor_d;
    logic          above_ratio_d;

    always_comb begin
        dc_floor_d    = PW'(dc_mag) * PW'(FLOOR_MUL);
        dc_ratio_d    = PW'(dc_mag) * PW'(KDC_DC);
        ac_ratio_d    = PW'(ac_mag) * PW'(KDC_AC);
        above_floor_d = dc_floor_d > PW'(NOM_PU);
        above_ratio_d = dc_ratio_d > ac_ratio_d;
        dc_hi_q       = zone_en && above_floor_d && above_ratio_d;
    end
endmodule

// File: rtl/dcfd_diff_chk.sv
module dcfd_diff_chk
    import dcfd_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0] dif_mag,
    input  logic [MAG_W-1:0] rst_mag,
    output logic             dif_low
);
    localparam int PW = MAG_W + GUARD_W;

    logic [PW-1:0] dif_scaled_d;

    always_comb begin
        dif_scaled_d = PW'(dif_mag) * PW'(KRD_DIF);
        dif_low      = dif_scaled_d < PW'(rst_mag);
    end
endmodule

// File: rtl/dcfd_qual_ctrl.sv
module dcfd_qual_ctrl #(
    parameter int SPC    = 16,
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_stb,
    input  logic dc_any,
    input  logic dif_low,
    output logic det
);
    localparam int LIMIT = SPC * CYCLES;
    localparam int CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sealed;
    } qual_t;

    qual_t st_d, st_q;
    logic  cond_d;

    always_comb begin
        st_d   = st_q;
        cond_d = dc_any && dif_low;
        if (st_q.sealed) begin
            // seal-in: differential check bypassed, release on DC decay
            if (!dc_any) begin
                st_d.sealed = 1'b0;
                st_d.cnt    = '0;
            end
        end else if (!cond_d) begin
            st_d.cnt = '0;
        end else if (smp_stb) begin
            if (st_q.cnt == CW'(LIMIT - 1)) begin
                st_d.sealed = 1'b1;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign det = st_q.sealed;

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !det && st_q.cnt == '0);
    a_r7_rise_on_limit: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> $past(smp_stb) && $past(st_q.cnt) == CW'(LIMIT - 1));
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < CW'(LIMIT));
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !det && !(dc_any && dif_low) |=> st_q.cnt == '0);
    a_r9_seal_hold: assert property (@(posedge clk) disable iff (rst)
        det && dc_any |=> det);
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        det && !dc_any |=> !det);
endmodule

// File: rtl/dc_offset_efd.sv
module dc_offset_efd
    import dcfd_pkg::*;
#(
    parameter int MAG_W  = 16,
    parameter int NOM_PU = 1000,
    parameter int SPC    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic [MAG_W-1:0] dc_mag_w,
    input  logic [MAG_W-1:0] ac_mag_w,
    input  logic             zone_en_w,
    input  logic [MAG_W-1:0] dc_mag_x,
    input  logic [MAG_W-1:0] ac_mag_x,
    input  logic             zone_en_x,
    input  logic [MAG_W-1:0] dif_mag,
    input  logic [MAG_W-1:0] rst_mag,
    output logic             efd_out
);
    logic [MAG_W-1:0] dc_arr [NTERM];
    logic [MAG_W-1:0] ac_arr [NTERM];
    logic [NTERM-1:0] zone_arr;
    logic [NTERM-1:0] hi_arr;
    logic             dc_any;
    logic             dif_low;

    assign dc_arr[0] = dc_mag_w;
    assign dc_arr[1] = dc_mag_x;
    assign ac_arr[0] = ac_mag_w;
    assign ac_arr[1] = ac_mag_x;
    assign zone_arr  = {zone_en_x, zone_en_w};

    for (genvar t = 0; t < NTERM; t++) begin : g_term
        dcfd_term_chk #(.MAG_W(MAG_W), .NOM_PU(NOM_PU)) u_chk (
            .dc_mag  (dc_arr[t]),
            .ac_mag  (ac_arr[t]),
            .zone_en (zone_arr[t]),
            .dc_hi_q (hi_arr[t])
        );
    end

    assign dc_any = |hi_arr;

    dcfd_diff_chk #(.MAG_W(MAG_W)) u_diff (
        .dif_mag (dif_mag),
        .rst_mag (rst_mag),
        .dif_low (dif_low)
    );

    dcfd_qual_ctrl #(.SPC(SPC), .CYCLES(3)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .dc_any  (dc_any),
        .dif_low (dif_low),
        .det     (efd_out)
    );

    a_r4_zone_gate: assert property (@(posedge clk) disable iff (rst)
        !zone_en_w && !zone_en_x && !efd_out |=> !efd_out);
endmodule

// File: tb/dc_offset_efd_tb_top.sv
`timescale 1ns/1ps
module dc_offset_efd_tb_top;
    localparam int MAG_W = 16;
    localparam int NOM   = 1000;
    localparam int SPC   = 16;
    localparam int LIM   = 3 * SPC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic [MAG_W-1:0] dcw = '0, acw = '0, dcx = '0, acx = '0, dif = '0, rstm = '0;
    logic zw = 1'b0, zx = 1'b0;
    logic out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dc_offset_efd #(.MAG_W(MAG_W), .NOM_PU(NOM), .SPC(SPC)) dut_i (
        .clk(clk), .rst(rst), .smp_stb(stb),
        .dc_mag_w(dcw), .ac_mag_w(acw), .zone_en_w(zw),
        .dc_mag_x(dcx), .ac_mag_x(acx), .zone_en_x(zx),
        .dif_mag(dif), .rst_mag(rstm), .efd_out(out)
    );

    task automatic chk(input logic exp, input string req);
        checks++;
        if (out !== exp) begin
            errors++;
            $display("FAIL %s: efd_out=%b expected=%b at %0t", req, out, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stb = 1'b0;
        dcw = '0; acw = '0; dcx = '0; acx = '0; zw = 1'b0; zx = 1'b0;
        dif = '0; rstm = 16'd100;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); stb = 1'b1;
            @(negedge clk); stb = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(1'b0, "R1 reset state");
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM);
        chk(1'b1, "R1 qualify before reset");
        do_reset();
        chk(1'b0, "R1 flag cleared by reset");
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM - 1);
        chk(1'b0, "R1 count cleared by reset");
    endtask

    task automatic t_floor();
        do_reset();
        dcw = 16'd200; zw = 1'b1;
        strobes(LIM + 2);
        chk(1'b0, "R2 DC equal to floor");
        dcw = 16'd201;
        strobes(LIM);
        chk(1'b1, "R2 DC above floor");
    endtask

    task automatic t_ratio();
        do_reset();
        dcw = 16'd300; acw = 16'd1000; zw = 1'b1;
        strobes(LIM + 2);
        chk(1'b0, "R3 DC equal to 0.3 AC");
        dcw = 16'd301;
        strobes(LIM);
        chk(1'b1, "R3 DC above 0.3 AC");
    endtask

    task automatic t_zone();
        do_reset();
        dcw = 16'd800; zw = 1'b0;
        strobes(LIM + 2);
        chk(1'b0, "R4 terminal out of zone ignored");
        do_reset();
        dcx = 16'd800; zx = 1'b1;
        strobes(LIM);
        chk(1'b1, "R5 second terminal alone qualifies");
        do_reset();
        dcw = 16'd800; zw = 1'b1; dcx = 16'd10; acx = 16'd900; zx = 1'b1;
        strobes(LIM);
        chk(1'b1, "R5 first terminal alone qualifies");
    endtask

    task automatic t_diff();
        do_reset();
        dcw = 16'd500; zw = 1'b1; dif = 16'd50;
        strobes(LIM + 2);
        chk(1'b0, "R6 DIF equal to half RST");
        dif = 16'd49;
        strobes(LIM);
        chk(1'b1, "R6 DIF below half RST");
    endtask

    task automatic t_timing();
        do_reset();
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM - 1);
        chk(1'b0, "R7 one strobe short");
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
        chk(1'b1, "R7 rises after final strobe");
    endtask

    task automatic t_drop();
        do_reset();
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM - 8);
        @(negedge clk); dif = 16'd90;
        @(negedge clk); dif = 16'd0;
        strobes(LIM - 1);
        chk(1'b0, "R8 count restarted after drop");
        strobes(1);
        chk(1'b1, "R8 full count after drop");
        // final strobe coincides with differential rise
        do_reset();
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM - 1);
        @(negedge clk); stb = 1'b1; dif = 16'd90;
        @(negedge clk); stb = 1'b0; dif = 16'd0;
        chk(1'b0, "R8 final strobe with DIF high");
        strobes(LIM - 1);
        chk(1'b0, "R8 restart after coincident drop");
        strobes(1);
        chk(1'b1, "R8 requalified");
    endtask

    task automatic t_seal();
        do_reset();
        dcw = 16'd500; zw = 1'b1;
        strobes(LIM);
        dif = 16'd400;
        strobes(10);
        chk(1'b1, "R9 sealed against high DIF");
        dcw = 16'd100;
        @(negedge clk);
        chk(1'b0, "R10 release on DC decay");
        dcw = 16'd500; dif = 16'd0;
        strobes(LIM - 1);
        chk(1'b0, "R10 full requalification needed");
        strobes(1);
        chk(1'b1, "R10 requalified");
        zw = 1'b0;
        @(negedge clk);
        chk(1'b0, "R10 release when zone enable drops");
    endtask

    initial begin
        t_reset();
        t_floor();
        t_ratio();
        t_zone();
        t_diff();
        t_timing();
        t_drop();
        t_seal();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule